// File: doc/BRIEF.md
# Complementary PWM Generator with Programmable Dead-Time

This block drives a pair of complementary switch-control outputs from a free-running 256-clock cycle counter. A pulse-width number chooses how long the high-side output is on in each cycle. The low-side output covers the rest of the cycle. When an output turns off, the opposite output waits a programmable dead-time before it turns on. Because of this, an on-time shorter than or equal to the dead-time is removed completely.

A small write port updates the settings. An asynchronous strobe passes through a two-flop synchroniser. On the rising edge of the synchronised strobe, the select line and data bus are latched into one of two settings: the pulse-width number or the dead-time field. A new width does not wait for a cycle boundary. It reaches the outputs after a fixed pipeline delay, so the cycle in which a write lands has a duty between the old and the new one.

Top module: `cpwm_deadband`

## Requirements
- R1: The two outputs are never high in the same clock. With a dead-time field of 0 and width W (1..254), the high-side output is high for exactly W clocks and the low-side output for exactly 256−W clocks in every 256-clock window.
- R2: With dead-time field N, each output waits 2·N clocks after the opposite output turns off before it turns on. For W in the mid range this gives W−2N high-side clocks, 256−W−2N low-side clocks, and 4N clocks per period with both outputs low.
- R3: An output whose raw on-time (W for the high side, 256−W for the low side) is at most 2·N clocks stays low for the whole cycle. The other output then loses 2·N clocks only once per period.
- R4: Width 0 holds the low-side output continuously high and the high-side output low. Width 255 holds the high-side output continuously high and the low-side output low. In both cases no dead-time gap appears, for any N.
- R5: The strobe is asynchronous. Settings load only on the rising edge of the two-flop synchronised strobe. With select 0 the 8-bit data bus loads the width. With select 1, data bits [2:0] load the dead-time field N and the width is left alone. Select and data must be held while the strobe is high. Bus activity while the strobe stays low has no effect.
- R6: The outputs reflect a new width at the 6th rising clock edge after the strobe rises, and not at the 5th. This holds in whatever part of the PWM cycle the write lands.
- R7: Both outputs are low during reset and stay low until the counter first wraps (at least 255 clocks after reset release). Width and N reset to 0.
- R8: The PWM period is exactly 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Asynchronous write strobe, active high |
| wr_sel | input | 1 | 0 = width number, 1 = dead-time field |
| wr_data | input | 8 | Write data |
| out_hi | output | 1 | High-side output, on for the commanded width |
| out_lo | output | 1 | Low-side output, on for the remainder |

## Verification
The bench targets the boundary where the on-time equals the dead-time (width 4 with N=2, and width 252 for the low side). A design that compares with the wrong inequality would let a one-clock pulse through there. It checks the 0 and 255 extremes with the largest N, where a design that inserts dead-time on every counter wrap would show a spurious gap. It measures the write-to-output latency edge by edge at two cycle phases, which catches an extra or missing pipeline stage and any deferral of the update to the cycle boundary. It also drives a dead-time-only write and bus activity with no strobe, which exposes decoding that touches the width.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {
        SEL_WIDTH = 1'b0,
        SEL_DEAD  = 1'b1
    } wsel_e;
endpackage

// File: rtl/cpwm_wrport.sv
module cpwm_wrport
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             sel_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] width_o,
    output logic [DT_W-1:0]  dead_o
);
    localparam int SYNC_W = 3;

    typedef struct packed {
        logic [SYNC_W-1:0] sync;
        logic [CNT_W-1:0]  width;
        logic [DT_W-1:0]   dead;
    } st_t;

    st_t  st_d, st_q;
    logic load;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_W-2:0], stb_i};
        load      = st_q.sync[1] & ~st_q.sync[2];
        if (load) begin
            if (wsel_e'(sel_i) == SEL_WIDTH) st_d.width = data_i;
            else                             st_d.dead  = data_i[DT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign width_o = st_q.width;
    assign dead_o  = st_q.dead;

    // R5: settings only move on a synchronised strobe rise
    a_r5_load_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(width_o) && $stable(dead_o)));
endmodule

// File: rtl/cpwm_core.sv
module cpwm_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] width_i,
    output logic             raw_o,
    output logic             en_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             started;
        logic [CNT_W-1:0] wuse;
        logic             raw;
        logic             en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = st_q.cnt + 1'b1;
        st_d.started = st_q.started | (&st_q.cnt);
        st_d.wuse    = width_i;
        st_d.raw     = (&st_q.wuse) | (st_q.cnt < st_q.wuse);
        st_d.en      = st_q.started;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;
    assign en_o  = st_q.en;

    // R8: counter wraps to zero after its last value
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.cnt) |=> (st_q.cnt == '0));
    // R6: width stage follows the latch by one clock
    a_r6_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wuse == $past(width_i));
endmodule

// File: rtl/cpwm_dtshape.sv
module cpwm_dtshape #(
    parameter int DT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic            en_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o
);
    localparam int RUN_W = DT_W + 2;

    typedef struct packed {
        logic             last;
        logic [RUN_W-1:0] run;
        logic             hi;
        logic             lo;
    } st_t;

    st_t              st_d, st_q;
    logic [RUN_W-1:0] span;
    logic             ok;

    always_comb begin
        st_d = st_q;
        span = {{(RUN_W-DT_W-1){1'b0}}, dead_i, 1'b0};
        if (raw_i != st_q.last) st_d.run = {{(RUN_W-1){1'b0}}, 1'b1};
        else if (&st_q.run)     st_d.run = st_q.run;
        else                    st_d.run = st_q.run + 1'b1;
        st_d.last = raw_i;
        ok        = st_d.run > span;
        st_d.hi   = en_i &  raw_i & ok;
        st_d.lo   = en_i & ~raw_i & ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));
    // R2: with nonzero dead-time, a turn-on never directly follows the other's on-state
    a_r2_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_o) && dead_i != '0 && $stable(dead_i)) |-> !$past(lo_o));
    a_r2_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_o) && dead_i != '0 && $stable(dead_i)) |-> !$past(hi_o));
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!hi_o && !lo_o));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int CNT_W = 8,
    parameter int DT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             out_hi,
    output logic             out_lo
);
    logic [CNT_W-1:0] width;
    logic [DT_W-1:0]  dead;
    logic             raw;
    logic             en;

    cpwm_wrport #(.CNT_W(CNT_W), .DT_W(DT_W)) i_wrport (
        .clk(clk), .rst_n(rst_n), .stb_i(wr_stb), .sel_i(wr_sel),
        .data_i(wr_data), .width_o(width), .dead_o(dead)
    );

    cpwm_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .width_i(width), .raw_o(raw), .en_o(en)
    );

    cpwm_dtshape #(.DT_W(DT_W)) i_shape (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .en_i(en), .dead_i(dead),
        .hi_o(out_hi), .lo_o(out_lo)
    );
endmodule

// File: tb/test_cpwm_deadband.sv
module test_cpwm_deadband;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       out_hi, out_lo;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cpwm_deadband i_cpwm_deadband (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .wr_data(wr_data), .out_hi(out_hi), .out_lo(out_lo)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(input logic sel, input int val);
        @(negedge clk);
        wr_sel = sel; wr_data = 8'(val); wr_stb = 1'b1;
        repeat (8) @(negedge clk);
        wr_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input int w, input int n);
        wr(1'b0, w);
        wr(1'b1, n);
        repeat (300) @(negedge clk);
    endtask

    task automatic measure(input string req, input int ehi, input int elo, input int eboth);
        int nhi = 0, nlo = 0, nov = 0, nnone = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (out_hi) nhi++;
            if (out_lo) nlo++;
            if (out_hi && out_lo) nov++;
            if (!out_hi && !out_lo) nnone++;
        end
        check({req, " high-side count"}, nhi, ehi);
        check({req, " low-side count"}, nlo, elo);
        check({req, " overlap R1"}, nov, 0);
        check({req, " both-low count"}, nnone, eboth);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 hi in reset", int'(out_hi), 0);
        check("R7 lo in reset", int'(out_lo), 0);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        check("R7 hi before first wrap", int'(out_hi), 0);
        check("R7 lo before first wrap", int'(out_lo), 0);
        repeat (200) @(negedge clk);
        check("R7 lo after start (width 0)", int'(out_lo), 1);
        check("R7 hi after start (width 0)", int'(out_hi), 0);
    endtask

    task automatic t_plain();
        setup(128, 0); measure("R1 W128 N0", 128, 128, 0);
        setup(37, 0);  measure("R1 W37 N0", 37, 219, 0);
    endtask

    task automatic t_dead();
        int gap = 0;
        setup(100, 3); measure("R2 W100 N3", 94, 150, 12);
        @(negedge clk);
        while (!(out_hi == 1'b0)) @(negedge clk);
        while (!out_hi) @(negedge clk);
        gap = 1; @(negedge clk);
        while (out_hi) begin gap++; @(negedge clk); end
        while (!out_hi) begin gap++; @(negedge clk); end
        check("R8 period between high-side rises", gap, 256);
    endtask

    task automatic t_swallow();
        setup(4, 2);   measure("R3 W4 N2 on-time equals dead", 0, 248, 8);
        setup(5, 2);   measure("R3 W5 N2 one clock survives", 1, 247, 8);
        setup(252, 2); measure("R3 W252 N2 low side swallowed", 248, 0, 8);
    endtask

    task automatic t_extremes();
        setup(0, 7);   measure("R4 W0 N7", 0, 256, 0);
        setup(255, 7); measure("R4 W255 N7", 256, 0, 0);
    endtask

    task automatic t_latency();
        logic s5, s6;
        setup(0, 0);
        // R6: width 0 -> 255, low side must drop at the 6th edge
        @(negedge clk);
        wr_sel = 1'b0; wr_data = 8'd255; wr_stb = 1'b1;
        s5 = 1'b0; s6 = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 5) s5 = out_lo;
            if (k == 6) s6 = out_lo;
        end
        check("R6 lo still on after 5 edges", int'(s5), 1);
        check("R6 lo off after 6 edges", int'(s6), 0);
        check("R6 hi on after 6 edges (N0)", int'(out_hi), 1);
        repeat (4) @(negedge clk);
        wr_stb = 1'b0;
        repeat (77) @(negedge clk);
        // R6: 255 -> 0 at another cycle phase
        wr_data = 8'd0; wr_stb = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 5) s5 = out_hi;
            if (k == 6) s6 = out_hi;
        end
        check("R6 hi still on after 5 edges", int'(s5), 1);
        check("R6 hi off after 6 edges", int'(s6), 0);
        repeat (4) @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic t_port();
        setup(100, 0); measure("R5 width write W100", 100, 156, 0);
        wr(1'b1, 1);
        repeat (300) @(negedge clk);
        measure("R5 dead-only write keeps width", 98, 154, 4);
        @(negedge clk);
        wr_sel = 1'b0; wr_data = 8'd200;
        repeat (300) @(negedge clk);
        wr_sel = 1'b1; wr_data = 8'd7;
        repeat (40) @(negedge clk);
        measure("R5 bus activity without strobe", 98, 154, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_plain();
        t_dead();
        t_swallow();
        t_extremes();
        t_latency();
        t_port();
        report();
    end
endmodule